// File: doc/BRIEF.md
# SKP Clock Tolerance Compensator

This block is an elastic buffer that sits between a receive clock recovered from a serial lane and the local core clock. The two clocks have the same nominal rate but come from separate references, so one side slowly runs ahead of the other. The buffer holds 8-bit symbols, each with a control flag. It keeps its fill near the middle by changing only the padding symbols inside skip ordered sets. When the write side is faster, it drops one padding symbol on the way in. When the read side is faster, it sends one padding symbol out twice. Data symbols and every other control symbol pass through unchanged and in order.

A skip ordered set is a comma control symbol followed by one to five skip control symbols. Each set allows at most one adjustment, and the first skip symbol of a set is never removed. Read and write pointers cross between the domains as Gray codes through multi-flop synchronisers. Each side compares its fill estimate, corrected by the synchroniser latency, against its thresholds. Two sticky flags record a hard overflow or a hard underflow. Two counters report how many skip symbols were deleted and how many were inserted.

Top module: `ctc_elastic_buffer`

## Requirements
- R1: Every non-skip symbol written (data with flag 0, and the comma: flag 1, byte 0xBC) leaves the read side exactly once and in write order. Only skip symbols (flag 1, byte 0x1C) are ever added or removed.
- R2: After reset, `out_valid`, `overflow`, `underflow` and both counters are 0. `out_valid` stays 0 until the read side sees the buffer filled close to its nominal level.
- R3: With a 1% clock offset in either direction and one skip ordered set every 40 symbols, neither `overflow` nor `underflow` is raised during a continuous stream.
- R4: When the write clock is faster, `del_count` increases and `ins_count` stays 0. A deletion happens only on a skip symbol that follows a comma and at least one kept skip symbol, so every set of three skip symbols comes out with two to four.
- R5: When the read clock is faster, `ins_count` increases and `del_count` stays 0, with at most one extra skip symbol for each set.
- R6: With equal clock rates, the stream passes with no deletion and no insertion.
- R7: A write into a full buffer sets `overflow`. The flag stays set until the write-side reset.
- R8: When the read side runs out of symbols, `underflow` is set, `out_valid` drops to 0, and the flag stays set until the read-side reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Recovered receive clock (write domain) |
| wrst | input | 1 | Synchronous active-high reset, write domain |
| in_valid | input | 1 | Input symbol present this write cycle |
| in_ctl | input | 1 | Input symbol is a control symbol |
| in_data | input | 8 | Input symbol byte |
| rclk | input | 1 | Local core clock (read domain) |
| rrst | input | 1 | Synchronous active-high reset, read domain |
| out_valid | output | 1 | Output symbol present this read cycle |
| out_ctl | output | 1 | Output symbol is a control symbol |
| out_data | output | 8 | Output symbol byte |
| overflow | output | 1 | Sticky: a write met a full buffer (write domain) |
| underflow | output | 1 | Sticky: reading met an empty buffer (read domain) |
| del_count | output | 16 | Skip symbols dropped (write domain) |
| ins_count | output | 16 | Skip symbols repeated (read domain) |

## Verification
On every cycle the assertions check several invariants: each pointer's Gray code changes by at most one bit, both fill views stay within the depth, an adjustment never falls on two consecutive cycles, a deletion or insertion never moves its own pointer, and both error flags stay set once raised. Only the bench scenarios can show the end-to-end behaviour. These include the order of symbols through the buffer under equal, fast and slow write clocks, the direction of correction that each offset produces, the number of skip symbols left in each set, the delayed start after reset, and the overflow and underflow cases.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

    typedef struct packed {
        logic       ctl;
        logic [7:0] data;
    } sym_t;

    localparam logic [7:0] K_COMMA = 8'hBC;
    localparam logic [7:0] K_SKIP  = 8'h1C;

    function automatic logic is_comma(input sym_t s);
        return s.ctl && (s.data == K_COMMA);
    endfunction

    function automatic logic is_skip(input sym_t s);
        return s.ctl && (s.data == K_SKIP);
    endfunction

endpackage

// File: rtl/ctc_gray_sync.sv
module ctc_gray_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] gray_out
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= gray_in;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= '0;
                else     chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign gray_out = chain[STAGES-1];
endmodule

// File: rtl/ctc_store.sv
module ctc_store
    import ctc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  sym_t          wsym,
    input  logic [AW-1:0] raddr,
    output sym_t          rsym
);
    sym_t mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wsym;
    end

    assign rsym = mem[raddr];
endmodule

// File: rtl/ctc_write_side.sv
module ctc_write_side
    import ctc_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int AW      = 4,
    parameter int HI      = 10,
    parameter int LAG     = 3,
    parameter int MAX_SKP = 5,
    parameter int CNT_W   = 16
) (
    input  logic          wclk,
    input  logic          wrst,
    input  logic          in_valid,
    input  sym_t          in_sym,
    input  logic [AW:0]   rd_gray_sync,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wr_gray,
    output logic          overflow,
    output logic [CNT_W-1:0] del_count
);
    localparam int PW = AW + 1;
    localparam int SW = $clog2(MAX_SKP + 1);
    localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
    localparam logic [PW-1:0] DEL_LVL  = PW'(HI + LAG);
    localparam logic [SW-1:0] SKP_LAST = SW'(MAX_SKP);

    logic [PW-1:0] wr_ptr, rd_bin, fill_w;
    logic          in_set, adj_done, full, del;
    logic [SW-1:0] skp_rx;

    always_comb begin
        rd_bin[PW-1] = rd_gray_sync[PW-1];
        for (int i = PW - 2; i >= 0; i--) rd_bin[i] = rd_bin[i+1] ^ rd_gray_sync[i];
    end

    assign fill_w = wr_ptr - rd_bin;
    assign full   = (fill_w == FULL_LVL);
    assign del    = in_valid && is_skip(in_sym) && in_set && (skp_rx != '0)
                    && !adj_done && (fill_w > DEL_LVL);
    assign we     = in_valid && !del && !full;
    assign waddr  = wr_ptr[AW-1:0];

    always_ff @(posedge wclk) begin
        if (wrst) begin
            wr_ptr    <= '0;
            wr_gray   <= '0;
            in_set    <= 1'b0;
            adj_done  <= 1'b0;
            skp_rx    <= '0;
            overflow  <= 1'b0;
            del_count <= '0;
        end else begin
            wr_gray <= wr_ptr ^ (wr_ptr >> 1);
            if (we) wr_ptr <= wr_ptr + 1'b1;
            if (in_valid && full) overflow <= 1'b1;
            if (del) begin
                adj_done  <= 1'b1;
                del_count <= del_count + 1'b1;
            end
            if (in_valid) begin
                if (is_comma(in_sym)) begin
                    in_set   <= 1'b1;
                    skp_rx   <= '0;
                    adj_done <= 1'b0;
                end else if (is_skip(in_sym) && in_set) begin
                    skp_rx <= skp_rx + 1'b1;
                    if (skp_rx + 1'b1 == SKP_LAST) in_set <= 1'b0;
                end else begin
                    in_set <= 1'b0;
                end
            end
        end
    end

    p_ovf_sticky_r7: assert property (@(posedge wclk) disable iff (wrst)
        overflow |=> overflow);
    p_del_spaced_r4: assert property (@(posedge wclk) disable iff (wrst)
        del |=> !del);
    p_del_no_write_r4: assert property (@(posedge wclk) disable iff (wrst)
        del |=> (wr_ptr == $past(wr_ptr)));
    p_wfill_bound_r3: assert property (@(posedge wclk) disable iff (wrst)
        fill_w <= FULL_LVL);
    p_wgray_step_r1: assert property (@(posedge wclk) disable iff (wrst)
        $onehot0(wr_gray ^ $past(wr_gray)));
endmodule

// File: rtl/ctc_read_side.sv
module ctc_read_side
    import ctc_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int AW      = 4,
    parameter int LO      = 6,
    parameter int MID     = 8,
    parameter int LAG     = 3,
    parameter int MAX_SKP = 5,
    parameter int CNT_W   = 16
) (
    input  logic          rclk,
    input  logic          rrst,
    input  logic [AW:0]   wr_gray_sync,
    input  sym_t          head,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rd_gray,
    output logic          out_valid,
    output sym_t          out_sym,
    output logic          underflow,
    output logic [CNT_W-1:0] ins_count
);
    localparam int PW = AW + 1;
    localparam int SW = $clog2(MAX_SKP + 1);
    localparam logic [PW-1:0] INS_LVL   = PW'(LO - LAG);
    localparam logic [PW-1:0] START_LVL = PW'(MID - LAG);
    localparam logic [PW-1:0] FULL_LVL  = PW'(DEPTH);
    localparam logic [SW-1:0] SKP_LAST  = SW'(MAX_SKP);

    logic [PW-1:0] rd_ptr, wr_bin, fill_r;
    logic          active, in_set, adj_done, empty, ins, pop;
    logic [SW-1:0] skp_tx;

    always_comb begin
        wr_bin[PW-1] = wr_gray_sync[PW-1];
        for (int i = PW - 2; i >= 0; i--) wr_bin[i] = wr_bin[i+1] ^ wr_gray_sync[i];
    end

    assign fill_r = wr_bin - rd_ptr;
    assign empty  = (fill_r == '0);
    assign ins    = active && !empty && is_skip(head) && in_set && !adj_done
                    && (fill_r < INS_LVL);
    assign pop    = active && !empty && !ins;
    assign raddr  = rd_ptr[AW-1:0];

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rd_ptr    <= '0;
            rd_gray   <= '0;
            active    <= 1'b0;
            in_set    <= 1'b0;
            adj_done  <= 1'b0;
            skp_tx    <= '0;
            out_valid <= 1'b0;
            out_sym   <= '0;
            underflow <= 1'b0;
            ins_count <= '0;
        end else begin
            rd_gray <= rd_ptr ^ (rd_ptr >> 1);
            if (!active) begin
                out_valid <= 1'b0;
                if (fill_r >= START_LVL) active <= 1'b1;
            end else if (empty) begin
                out_valid <= 1'b0;
                active    <= 1'b0;
                underflow <= 1'b1;
            end else begin
                out_valid <= 1'b1;
                out_sym   <= head;
                if (pop) rd_ptr <= rd_ptr + 1'b1;
                if (is_comma(head)) begin
                    in_set   <= 1'b1;
                    skp_tx   <= '0;
                    adj_done <= 1'b0;
                end else if (is_skip(head) && in_set) begin
                    if (ins) begin
                        adj_done  <= 1'b1;
                        ins_count <= ins_count + 1'b1;
                    end else begin
                        skp_tx <= skp_tx + 1'b1;
                        if (skp_tx + 1'b1 == SKP_LAST) in_set <= 1'b0;
                    end
                end else begin
                    in_set <= 1'b0;
                end
            end
        end
    end

    p_unf_sticky_r8: assert property (@(posedge rclk) disable iff (rrst)
        underflow |=> underflow);
    p_ins_spaced_r5: assert property (@(posedge rclk) disable iff (rrst)
        ins |=> !ins);
    p_ins_holds_ptr_r5: assert property (@(posedge rclk) disable iff (rrst)
        ins |=> (rd_ptr == $past(rd_ptr)) && out_sym.ctl && (out_sym.data == K_SKIP));
    p_rfill_bound_r3: assert property (@(posedge rclk) disable iff (rrst)
        fill_r <= FULL_LVL);
    p_rgray_step_r1: assert property (@(posedge rclk) disable iff (rrst)
        $onehot0(rd_gray ^ $past(rd_gray)));
endmodule

// File: rtl/ctc_elastic_buffer.sv
module ctc_elastic_buffer
    import ctc_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int MID_LVL     = 8,
    parameter int HI_LVL      = 10,
    parameter int LO_LVL      = 6,
    parameter int MAX_SKP     = 5,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 16
) (
    input  logic             wclk,
    input  logic             wrst,
    input  logic             in_valid,
    input  logic             in_ctl,
    input  logic [7:0]       in_data,
    input  logic             rclk,
    input  logic             rrst,
    output logic             out_valid,
    output logic             out_ctl,
    output logic [7:0]       out_data,
    output logic             overflow,
    output logic             underflow,
    output logic [CNT_W-1:0] del_count,
    output logic [CNT_W-1:0] ins_count
);
    localparam int AW  = $clog2(DEPTH);
    localparam int LAG = SYNC_STAGES + 1;

    sym_t          wsym, rsym, osym;
    logic          we;
    logic [AW-1:0] waddr, raddr;
    logic [AW:0]   wr_gray, rd_gray, wr_gray_s, rd_gray_s;

    assign wsym = '{ctl: in_ctl, data: in_data};

    ctc_write_side #(.DEPTH(DEPTH), .AW(AW), .HI(HI_LVL), .LAG(LAG),
                     .MAX_SKP(MAX_SKP), .CNT_W(CNT_W)) u_wr (
        .wclk(wclk), .wrst(wrst), .in_valid(in_valid), .in_sym(wsym),
        .rd_gray_sync(rd_gray_s), .we(we), .waddr(waddr), .wr_gray(wr_gray),
        .overflow(overflow), .del_count(del_count));

    ctc_store #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .wclk(wclk), .we(we), .waddr(waddr), .wsym(wsym),
        .raddr(raddr), .rsym(rsym));

    ctc_gray_sync #(.W(AW + 1), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rclk), .rst(rrst), .gray_in(wr_gray), .gray_out(wr_gray_s));

    ctc_gray_sync #(.W(AW + 1), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wclk), .rst(wrst), .gray_in(rd_gray), .gray_out(rd_gray_s));

    ctc_read_side #(.DEPTH(DEPTH), .AW(AW), .LO(LO_LVL), .MID(MID_LVL), .LAG(LAG),
                    .MAX_SKP(MAX_SKP), .CNT_W(CNT_W)) u_rd (
        .rclk(rclk), .rrst(rrst), .wr_gray_sync(wr_gray_s), .head(rsym),
        .raddr(raddr), .rd_gray(rd_gray), .out_valid(out_valid), .out_sym(osym),
        .underflow(underflow), .ins_count(ins_count));

    assign out_ctl  = osym.ctl;
    assign out_data = osym.data;
endmodule

// File: tb/tb_ctc_elastic_buffer.sv
`timescale 1ns/1ps
module tb_ctc_elastic_buffer;
    logic wclk = 1'b0, rclk = 1'b0;
    logic wrst = 1'b1, rrst = 1'b1;
    logic in_valid = 1'b0, in_ctl = 1'b0;
    logic [7:0] in_data = '0;
    logic out_valid, out_ctl, overflow, underflow;
    logic [7:0] out_data;
    logic [15:0] del_count, ins_count;

    real whp = 10.0;
    int  checks = 0, errors = 0;
    bit  done = 1'b0, mon_en = 1'b0, in_oset = 1'b0;
    int  skp_seen = 0;
    logic [7:0] seq = '0;
    logic [8:0] exp_q [$];

    ctc_elastic_buffer dut (
        .wclk(wclk), .wrst(wrst), .in_valid(in_valid), .in_ctl(in_ctl), .in_data(in_data),
        .rclk(rclk), .rrst(rrst), .out_valid(out_valid), .out_ctl(out_ctl),
        .out_data(out_data), .overflow(overflow), .underflow(underflow),
        .del_count(del_count), .ins_count(ins_count));

    initial forever #10 rclk = ~rclk;
    initial forever #(whp) wclk = ~wclk;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Output monitor: order (R1), skip symbols per set (R4/R5)
    always @(negedge rclk) begin
        if (mon_en && out_valid) begin
            if (out_ctl && out_data == 8'h1C) begin
                if (in_oset) skp_seen++;
                else check(1'b0, "R1 stray skip", 0, 1);
            end else begin
                if (in_oset) begin
                    in_oset = 1'b0;
                    check(skp_seen >= 2 && skp_seen <= 4, "R4/R5 skips per set", skp_seen, 3);
                end
                if (exp_q.size() == 0) check(1'b0, "R1 unexpected symbol", int'({out_ctl, out_data}), -1);
                else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    check({out_ctl, out_data} == e, "R1 order", int'({out_ctl, out_data}), int'(e));
                end
                if (out_ctl && out_data == 8'hBC) begin
                    in_oset = 1'b1;
                    skp_seen = 0;
                end
            end
        end
    end

    task automatic do_reset(input real half);
        mon_en = 1'b0;
        in_valid = 1'b0;
        wrst = 1'b1;
        rrst = 1'b1;
        whp = half;
        repeat (6) @(posedge rclk);
        repeat (3) @(posedge wclk);
        exp_q.delete();
        in_oset = 1'b0;
        skp_seen = 0;
        @(negedge wclk) wrst = 1'b0;
        @(negedge rclk) rrst = 1'b0;
    endtask

    task automatic put(input logic c, input logic [7:0] d, input bit track);
        @(negedge wclk);
        in_valid = 1'b1;
        in_ctl = c;
        in_data = d;
        if (track && !(c && d == 8'h1C)) exp_q.push_back({c, d});
    endtask

    task automatic stop_input();
        @(negedge wclk) in_valid = 1'b0;
    endtask

    task automatic send_sets(input int n, input int gap);
        for (int s = 0; s < n; s++) begin
            put(1'b1, 8'hBC, 1'b1);
            for (int k = 0; k < 3; k++) put(1'b1, 8'h1C, 1'b1);
            for (int k = 0; k < gap; k++) begin
                put(1'b0, seq, 1'b1);
                seq = seq + 8'd1;
            end
        end
    endtask

    task automatic t_reset_and_prime();
        do_reset(10.0);
        @(negedge rclk);
        check(out_valid == 1'b0, "R2 out_valid after reset", out_valid, 0);
        check(overflow == 1'b0, "R2 overflow after reset", overflow, 0);
        check(underflow == 1'b0, "R2 underflow after reset", underflow, 0);
        check(del_count == 16'd0, "R2 del_count after reset", del_count, 0);
        check(ins_count == 16'd0, "R2 ins_count after reset", ins_count, 0);
        put(1'b0, 8'h11, 1'b0);
        put(1'b0, 8'h22, 1'b0);
        stop_input();
        repeat (20) @(negedge rclk);
        check(out_valid == 1'b0, "R2 no output before priming", out_valid, 0);
        check(underflow == 1'b0, "R2 no underflow before priming", underflow, 0);
    endtask

    task automatic t_rate(input real half, input string tag, input int want_del, input int want_ins);
        do_reset(half);
        mon_en = 1'b1;
        send_sets(60, 36);
        @(negedge rclk);
        check(overflow == 1'b0, {"R3 no overflow ", tag}, overflow, 0);
        check(underflow == 1'b0, {"R3 no underflow ", tag}, underflow, 0);
        if (want_del > 0) check(del_count > 0, {"R4 deletions ", tag}, del_count, 1);
        else check(del_count == 0, {"R4/R6 no deletions ", tag}, del_count, 0);
        if (want_ins > 0) check(ins_count > 0, {"R5 insertions ", tag}, ins_count, 1);
        else check(ins_count == 0, {"R5/R6 no insertions ", tag}, ins_count, 0);
        mon_en = 1'b0;
        stop_input();
    endtask

    task automatic t_overflow();
        do_reset(5.0);
        for (int k = 0; k < 120; k++) put(1'b0, 8'(k), 1'b0);
        stop_input();
        @(negedge wclk);
        check(overflow == 1'b1, "R7 overflow set", overflow, 1);
        repeat (60) @(negedge wclk);
        check(overflow == 1'b1, "R7 overflow sticky", overflow, 1);
        wrst = 1'b1;
        repeat (2) @(negedge wclk);
        check(overflow == 1'b0, "R7 overflow cleared by reset", overflow, 0);
        wrst = 1'b0;
    endtask

    task automatic t_underflow();
        do_reset(10.0);
        mon_en = 1'b1;
        send_sets(2, 20);
        stop_input();
        repeat (40) @(negedge rclk);
        check(underflow == 1'b1, "R8 underflow set", underflow, 1);
        check(out_valid == 1'b0, "R8 out_valid dropped", out_valid, 0);
        check(exp_q.size() == 0, "R1 all symbols delivered", exp_q.size(), 0);
        mon_en = 1'b0;
        repeat (20) @(negedge rclk);
        check(underflow == 1'b1, "R8 underflow sticky", underflow, 1);
        rrst = 1'b1;
        repeat (2) @(negedge rclk);
        check(underflow == 1'b0, "R8 underflow cleared by reset", underflow, 0);
        rrst = 1'b0;
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset_and_prime();
        t_rate(10.0, "equal", 0, 0);
        t_rate(9.9, "fast write", 1, 0);
        t_rate(10.1, "slow write", 0, 1);
        t_overflow();
        t_underflow();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule